// File: doc/BRIEF.md
# Multiplexed Bus to Static RAM Glue

This block sits between a processor bus that shares one byte lane for the low address and the data, and an 8K x 8 static RAM. Each bus cycle has two halves. While the phase clock E is low, the processor puts the low address byte on the shared lane and pulses the address strobe. While E is high, data moves across the lane. The glue keeps the low address byte in a register and joins it to the upper address bits to form the 13-bit RAM address. It decodes the three top address bits into an active-low RAM select. It derives active-low write and read strobes from the read/write line. It also decides which side drives the shared lane and the RAM data pins.

Every select and strobe is qualified by E, so the RAM can never be enabled during the address half. One decoder output is chosen by a parameter, which places the RAM in a single 8 KB window. The default output 2 puts it at base 0x4000. All logic is clocked by a fast sampling clock that runs many times faster than E. Each output is a registered copy of the bus state that was sampled one clock earlier.

Top module: `membus_sram_glue`

## Requirements
- R1: While rst_n is low at a clock edge, the next outputs are: ram_ce_n, ram_we_n and ram_oe_n high, lane_drv and ram_wr_drv low, ram_addr zero, ram_din zero and lane_out zero.
- R2: ram_addr[7:0] takes the lane_in value one clock after a sample in which bus_as is 1 and bus_e is 0. In every other sample, including a strobe pulse while bus_e is 1, it keeps its value.
- R3: ram_addr[12:8] equals addr_hi[4:0] as sampled one clock earlier.
- R4: ram_ce_n is low one clock after a sample in which bus_e is 1 and addr_hi[7:5] equals the parameter DEC_SEL (default 2, window 0x4000 to 0x5FFF). Otherwise it is high.
- R5: One clock after any sample with bus_e at 0, all three of ram_ce_n, ram_we_n and ram_oe_n are high.
- R6: ram_we_n is low one clock after a sample with bus_e = 1 and bus_rw = 0 (write). ram_oe_n is low one clock after a sample with bus_e = 1 and bus_rw = 1 (read). The two are never low together.
- R7: ram_din is lane_in as sampled one clock earlier when that sample had bus_e = 1 and bus_rw = 0. Otherwise it holds. ram_wr_drv is 1 exactly when ram_ce_n and ram_we_n are both low.
- R8: lane_drv is 1 exactly when ram_ce_n and ram_oe_n are both low. lane_out equals ram_dq_in while lane_drv is 1 and is zero otherwise, so the lane is released one clock after E falls.
- R9: An address outside the selected window never enables the RAM, whatever the state of E and R/W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_e | input | 1 | Bus phase clock: 0 is the address half, 1 is the data half |
| bus_as | input | 1 | Address strobe, active high |
| bus_rw | input | 1 | 1 for read, 0 for write |
| addr_hi | input | 8 | Upper address byte, bits 15..8 |
| lane_in | input | 8 | Shared address/data lane as driven by the processor |
| ram_dq_in | input | 8 | Data pins of the RAM as driven by the RAM |
| ram_addr | output | 13 | RAM address, bits 12..0 |
| ram_ce_n | output | 1 | RAM select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_din | output | 8 | Write data presented to the RAM pins |
| ram_wr_drv | output | 1 | Enable for driving ram_din onto the RAM pins |
| lane_out | output | 8 | Read data for the shared lane |
| lane_drv | output | 1 | Enable for driving lane_out onto the shared lane |

## Verification
Every registered output is due exactly one clock after the sample that causes it. The address byte, the upper address, the select, both strobes and the write data all follow the inputs from the edge before. The two lane enables are due in the same clock as the select and strobes, because they are formed from those registered outputs. lane_out follows ram_dq_in with no clock delay. The bench changes inputs on the falling clock edge. It checks on the next falling edge against a model that is updated with the inputs applied before the rising edge in between. It re-reads ram_dq_in at the moment of each check.

// File: rtl/glue_pkg.sv
// Package: shared widths and reset values for the bus-to-RAM glue.
// Assumes an 8-bit low address byte multiplexed with 8-bit data.
package glue_pkg;
    localparam int unsigned LANE_W     = 8;
    localparam int unsigned HI_W       = 8;
    localparam int unsigned RAM_AW     = 13;
    localparam int unsigned DEF_SEL    = 2;
    localparam logic        STROBE_OFF = 1'b1;
endpackage

// File: rtl/addr_capture.sv
// addr_capture: holds the low address byte that appears on the shared lane
// during the E-low half, and registers the upper RAM address bits.
// Assumes the strobe is sampled by a clock much faster than E.
module addr_capture #(
    parameter int unsigned LANE_W = glue_pkg::LANE_W,
    parameter int unsigned UP_W   = glue_pkg::RAM_AW - glue_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_e,
    input  logic              bus_as,
    input  logic [LANE_W-1:0] lane_in,
    input  logic [UP_W-1:0]   up_in,
    output logic [LANE_W-1:0] lo_q,
    output logic [UP_W-1:0]   up_q
);
    logic take_lo;
    assign take_lo = bus_as && !bus_e;

    // Capture the low byte only on a strobe in the address half.
    always_ff @(posedge clk) begin
        if (!rst_n)       lo_q <= '0;
        else if (take_lo) lo_q <= lane_in;
    end

    // Register the upper RAM address bits every sample.
    always_ff @(posedge clk) begin
        if (!rst_n) up_q <= '0;
        else        up_q <= up_in;
    end

    // R2: without a valid strobe the low byte must not move.
    a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_as && !bus_e) |=> $stable(lo_q));
endmodule

// File: rtl/window_decode.sv
// window_decode: one-of-eight decode of the top address bits, enabled
// only while E is high; one output, picked by DEC_SEL, becomes the RAM select.
// Assumes DEC_SEL is below 2**SEL_W.
module window_decode #(
    parameter int unsigned SEL_W   = 3,
    parameter int unsigned DEC_SEL = glue_pkg::DEF_SEL,
    localparam int unsigned N_OUT  = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_e,
    input  logic [SEL_W-1:0] top_bits,
    output logic             ce_n
);
    logic [N_OUT-1:0] dec_n;

    // Build the active-low decoder outputs.
    for (genvar i = 0; i < N_OUT; i++) begin : g_dec
        assign dec_n[i] = !(bus_e && (top_bits == SEL_W'(i)));
    end

    // Register the chosen decoder output as the RAM select.
    always_ff @(posedge clk) begin
        if (!rst_n) ce_n <= glue_pkg::STROBE_OFF;
        else        ce_n <= dec_n[DEC_SEL];
    end

    // R5: no select after an address-half sample.
    a_r5_ce_idle_e_low: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_e |=> ce_n);
    // R9: no select for another window.
    a_r9_ce_window_only: assert property (@(posedge clk) disable iff (!rst_n)
        (top_bits != SEL_W'(DEC_SEL)) |=> ce_n);
endmodule

// File: rtl/strobe_gen.sv
// strobe_gen: forms active-low write and read strobes from R/W and E,
// and keeps the write data sampled from the lane during a write half.
// Assumes bus_rw is 1 for read, 0 for write.
module strobe_gen #(
    parameter int unsigned LANE_W = glue_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_e,
    input  logic              bus_rw,
    input  logic [LANE_W-1:0] lane_in,
    output logic              we_n,
    output logic              oe_n,
    output logic [LANE_W-1:0] wdata
);
    logic wr_half, rd_half;
    assign wr_half = bus_e && !bus_rw;
    assign rd_half = bus_e &&  bus_rw;

    // Register both strobes, each gated by E.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_n <= glue_pkg::STROBE_OFF;
            oe_n <= glue_pkg::STROBE_OFF;
        end else begin
            we_n <= !wr_half;
            oe_n <= !rd_half;
        end
    end

    // Sample write data from the lane during a write half.
    always_ff @(posedge clk) begin
        if (!rst_n)       wdata <= '0;
        else if (wr_half) wdata <= lane_in;
    end

    // R5: strobes idle after an address-half sample.
    a_r5_strobes_idle_e_low: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_e |=> (we_n && oe_n));
    // R6: write and read strobes never overlap.
    a_r6_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));
    // R7: write data holds outside a write half.
    a_r7_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_half |=> $stable(wdata));
endmodule

// File: rtl/membus_sram_glue.sv
// membus_sram_glue: top of the glue between a multiplexed address/data bus
// and an 8K x 8 static RAM. Joins the address, decodes the window, forms
// strobes and steers the shared lane. Assumes a fast sampling clock.
module membus_sram_glue #(
    parameter int unsigned LANE_W  = glue_pkg::LANE_W,
    parameter int unsigned HI_W    = glue_pkg::HI_W,
    parameter int unsigned RAM_AW  = glue_pkg::RAM_AW,
    parameter int unsigned DEC_SEL = glue_pkg::DEF_SEL,
    localparam int unsigned UP_W   = RAM_AW - LANE_W,
    localparam int unsigned SEL_W  = HI_W + LANE_W - RAM_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_e,
    input  logic              bus_as,
    input  logic              bus_rw,
    input  logic [HI_W-1:0]   addr_hi,
    input  logic [LANE_W-1:0] lane_in,
    input  logic [LANE_W-1:0] ram_dq_in,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_ce_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [LANE_W-1:0] ram_din,
    output logic              ram_wr_drv,
    output logic [LANE_W-1:0] lane_out,
    output logic              lane_drv
);
    logic [LANE_W-1:0] lo_q;
    logic [UP_W-1:0]   up_q;

    addr_capture #(.LANE_W(LANE_W), .UP_W(UP_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_e   (bus_e),
        .bus_as  (bus_as),
        .lane_in (lane_in),
        .up_in   (addr_hi[UP_W-1:0]),
        .lo_q    (lo_q),
        .up_q    (up_q)
    );

    window_decode #(.SEL_W(SEL_W), .DEC_SEL(DEC_SEL)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_e    (bus_e),
        .top_bits (addr_hi[HI_W-1 -: SEL_W]),
        .ce_n     (ram_ce_n)
    );

    strobe_gen #(.LANE_W(LANE_W)) u_stb (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_e   (bus_e),
        .bus_rw  (bus_rw),
        .lane_in (lane_in),
        .we_n    (ram_we_n),
        .oe_n    (ram_oe_n),
        .wdata   (ram_din)
    );

    // Join the registered address halves.
    assign ram_addr = {up_q, lo_q};

    // Steer the lane and RAM pins from the registered select and strobes.
    always_comb begin
        ram_wr_drv = !ram_ce_n && !ram_we_n;
        lane_drv   = !ram_ce_n && !ram_oe_n;
        lane_out   = lane_drv ? ram_dq_in : '0;
    end

    // R8: the lane is released whenever the RAM is not selected.
    a_r8_lane_release: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce_n |-> !lane_drv);
    // R7: the RAM pins are driven only for a write strobe.
    a_r7_wr_drv_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_drv |-> !ram_we_n);
    // R8: lane and RAM pins are never driven at once.
    a_r8_no_double_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lane_drv && ram_wr_drv));
endmodule

// File: tb/membus_sram_glue_test.sv
module membus_sram_glue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_e = 1'b0, bus_as = 1'b0, bus_rw = 1'b1;
    logic [7:0]  addr_hi = '0, lane_in = '0, ram_dq_in = '0;
    logic [12:0] ram_addr;
    logic        ram_ce_n, ram_we_n, ram_oe_n, ram_wr_drv, lane_drv;
    logic [7:0]  ram_din, lane_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // model state, built from the requirements
    logic [7:0] m_lo = '0, m_wd = '0;
    logic [4:0] m_up = '0;

    always #4 clk = ~clk;

    membus_sram_glue uut (
        .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_as(bus_as),
        .bus_rw(bus_rw), .addr_hi(addr_hi), .lane_in(lane_in),
        .ram_dq_in(ram_dq_in), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n),
        .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_din(ram_din),
        .ram_wr_drv(ram_wr_drv), .lane_out(lane_out), .lane_drv(lane_drv)
    );

    function automatic logic f_ce_n(input logic e, input logic [7:0] hi);
        return !(e && hi[7:5] == 3'd2);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Apply one sample, then check every output one clock later.
    task automatic step(input logic e, input logic as_, input logic rw,
                        input logic [7:0] hi, input logic [7:0] ln,
                        input logic [7:0] dq);
        logic ce, we, oe;
        bus_e = e; bus_as = as_; bus_rw = rw; addr_hi = hi; lane_in = ln;
        @(posedge clk);
        if (as_ && !e) m_lo = ln;
        if (e && !rw)  m_wd = ln;
        m_up = hi[4:0];
        ce = f_ce_n(e, hi);
        we = !(e && !rw);
        oe = !(e && rw);
        @(negedge clk);
        ram_dq_in = dq;
        #1;
        check("R2 low addr", int'(ram_addr[7:0]), int'(m_lo));
        check("R3 high addr", int'(ram_addr[12:8]), int'(m_up));
        check("R4 ce_n", int'(ram_ce_n), int'(ce));
        check("R6 we_n", int'(ram_we_n), int'(we));
        check("R6 oe_n", int'(ram_oe_n), int'(oe));
        if (!e) check("R5 idle strobes", int'({ram_ce_n, ram_we_n, ram_oe_n}), 7);
        check("R7 ram_din", int'(ram_din), int'(m_wd));
        check("R7 wr_drv", int'(ram_wr_drv), int'(!ce && !we));
        check("R8 lane_drv", int'(lane_drv), int'(!ce && !oe));
        check("R8 lane_out", int'(lane_out), (!ce && !oe) ? int'(dq) : 0);
        if (hi[7:5] != 3'd2) check("R9 outside window", int'(ram_ce_n), 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R1: reset with busy-looking inputs
        bus_e = 1'b1; bus_as = 1'b1; bus_rw = 1'b0; addr_hi = 8'h45; lane_in = 8'hA5;
        ram_dq_in = 8'h3C;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ce_n", int'(ram_ce_n), 1);
        check("R1 we_n", int'(ram_we_n), 1);
        check("R1 oe_n", int'(ram_oe_n), 1);
        check("R1 drives", int'({lane_drv, ram_wr_drv}), 0);
        check("R1 addr", int'(ram_addr), 0);
        check("R1 data", int'({ram_din, lane_out}), 0);
        rst_n = 1'b1;

        // Directed: full write cycle then read cycle at 0x4123
        step(1'b0, 1'b1, 1'b0, 8'h41, 8'h23, 8'h00);
        step(1'b0, 1'b0, 1'b0, 8'h41, 8'h99, 8'h00);
        step(1'b1, 1'b0, 1'b0, 8'h41, 8'h5A, 8'h00);
        step(1'b1, 1'b0, 1'b0, 8'h41, 8'h5A, 8'h00);
        step(1'b0, 1'b1, 1'b1, 8'h41, 8'h23, 8'hC3);
        step(1'b1, 1'b0, 1'b1, 8'h41, 8'h00, 8'hC3);
        step(1'b0, 1'b0, 1'b1, 8'h41, 8'h00, 8'hC3);
        // R2: strobe during E high ignored
        step(1'b1, 1'b1, 1'b1, 8'h41, 8'hEE, 8'h11);
        check("R2 strobe in E high ignored", int'(ram_addr[7:0]), 8'h23);
        // R9: window edges 0x3FFF and 0x6000
        step(1'b1, 1'b0, 1'b1, 8'h3F, 8'h00, 8'h77);
        step(1'b1, 1'b0, 1'b0, 8'h60, 8'h00, 8'h77);
        step(1'b1, 1'b0, 1'b1, 8'h5F, 8'h00, 8'h77);
        step(1'b1, 1'b0, 1'b1, 8'h40, 8'h00, 8'h88);

        // Random mix, biased towards the selected window
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] hi;
            hi = 8'($urandom);
            if (($urandom % 2) == 0) hi[7:5] = 3'd2;
            step(1'($urandom), 1'($urandom), 1'($urandom), hi,
                 8'($urandom), 8'($urandom));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule